// File: doc/BRIEF.md
# Glitch-Free Clock Source Selector

This block picks one of up to four incoming clocks and drives it onto a single output. Software writes a source code into a pending select register. The code stays pending and has no effect until the update register sees a write of 0 and then a write of 1. When the code is committed, the block hands the output over from the old clock to the new one without producing a shortened pulse, even when the two clocks are unrelated.

Typical use is two instances. One chooses the main clock from four sources: internal RC, PLL input, watchdog oscillator and PLL output. The other chooses the PLL reference from three sources: internal RC, system oscillator and external clock input. In that instance the fourth code selects nothing and holds the output low.

A generate option adds an output divider. Its register is written after the source update. The divided output toggles once every N rising edges of the selected clock, and a value of 0 turns the output off.

Top module: `clksel_top`

## Requirements
- R1: While reset is applied and just after it ends, the active code reads 0, and the divider register holds 1. Once the status bit clears, the output follows source 0.
- R2: A write to the select register (address 0) changes neither the active code nor the output clock.
- R3: The update register is at address 1 and only its bit 0 is decoded. The pending code becomes active only on a write of 1 that follows a write of 0. A write of 1 with no preceding 0 is ignored, and so is a second write of 1.
- R4: Only the low two bits of a select write are stored. Upper data bits are ignored.
- R5: Code k drives source k onto the output, so the output period equals the period of source k.
- R6: Across a switchover, no high or low phase of the output is shorter than the shortest half-period of the sources involved.
- R7: At most one source is enabled at any time. Every high phase of the output is a whole high phase of a single source.
- R8: The status output reads 1 from the cycle that commits a new code until the new source drives the output, then reads 0.
- R9: When the active code has no source attached, the output is held low and the status bit clears once the old source is off.
- R10: The divider register is at address 2. A value N greater than 0 makes the divided output toggle every N rising edges of the selected clock, giving a period of 2·N source periods. A value of 0 holds the divided output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk_i | input | 1 | Register interface clock |
| cfg_rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 2 | Register address: 0 select, 1 update, 2 divider |
| wr_data_i | input | DATA_W | Write data |
| src_clk_i | input | N_SRC | Candidate clocks, bit k is code k |
| mux_clk_o | output | 1 | Selected clock |
| div_clk_o | output | 1 | Divided selected clock (low when the divider option is off) |
| act_sel_o | output | SEL_W | Active (committed) source code |
| busy_o | output | 1 | Switchover in progress |

## Verification
The checker assumes that source clocks keep running while they are being turned off, because each lane needs edges of its own clock to drop its enable. The directed stimulus therefore keeps every bench clock free-running. It also assumes that write strobes are synchronous to the register clock, so the bench drives them on its falling edge. The checker relies on a new code being committed only after the previous handover has settled, and each bench scenario waits for the status bit to clear before issuing the next update.

// File: rtl/clksel_pkg.sv
`timescale 1ns/1ps
package clksel_pkg;
   // register address map of the write port
   typedef enum logic [1:0] {
      REG_SEL = 2'd0,
      REG_UPD = 2'd1,
      REG_DIV = 2'd2,
      REG_NONE = 2'd3
   } reg_addr_e;

   localparam int unsigned ADDR_W = 2;
endpackage

// File: rtl/clksel_regs.sv
`timescale 1ns/1ps
// Register file: pending code, update arm/commit, divider value.
module clksel_regs #(
   parameter int unsigned SEL_W  = 2,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DIV_W  = 8
) (
   input  logic                                  cfg_clk,
   input  logic                                  rst_n,
   input  logic                                  wr_en,
   input  logic [clksel_pkg::ADDR_W-1:0]         wr_addr,
   input  logic [DATA_W-1:0]                     wr_data,
   output logic [SEL_W-1:0]                      act_sel,
   output logic [DIV_W-1:0]                      div_val
);
   import clksel_pkg::*;

   logic [SEL_W-1:0] pend_sel;
   logic             armed;

   always_ff @(posedge cfg_clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_sel <= '0;
         act_sel  <= '0;
         armed    <= 1'b0;
         div_val  <= DIV_W'(1);
      end else if (wr_en) begin
         case (wr_addr)
            REG_SEL: pend_sel <= wr_data[SEL_W-1:0];
            REG_UPD: begin
               if (!wr_data[0]) begin
                  armed <= 1'b1;
               end else begin
                  if (armed) act_sel <= pend_sel;
                  armed <= 1'b0;
               end
            end
            REG_DIV: div_val <= wr_data[DIV_W-1:0];
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/clksel_lane.sv
`timescale 1ns/1ps
// One source lane: request synchronised on the source's rising edge,
// enable launched on its falling edge so the gate opens/closes while low.
module clksel_lane #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic src_clk,
   input  logic rst_n,
   input  logic req,
   output logic en
);
   logic [SYNC_STAGES-1:0] sync_q;

   always_ff @(posedge src_clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], req};
   end

   always_ff @(negedge src_clk or negedge rst_n) begin
      if (!rst_n) en <= 1'b0;
      else        en <= sync_q[SYNC_STAGES-1];
   end
endmodule

// File: rtl/clksel_status.sv
`timescale 1ns/1ps
// Brings lane enables into the register domain and compares with the target.
module clksel_status #(
   parameter int unsigned SEL_W       = 2,
   parameter int unsigned N_SRC       = 4,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned NCODE      = 1 << SEL_W
) (
   input  logic             cfg_clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] act_sel,
   input  logic [NCODE-1:0] lane_en,
   output logic             busy
);
   logic [NCODE-1:0] sync_q [SYNC_STAGES];
   logic [NCODE-1:0] target;

   always_ff @(posedge cfg_clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
      end else begin
         sync_q[0] <= lane_en;
         for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
      end
   end

   always_comb begin
      for (int k = 0; k < NCODE; k++)
         target[k] = (act_sel == SEL_W'(k)) && (k < N_SRC);
   end

   assign busy = (sync_q[SYNC_STAGES-1] != target);
endmodule

// File: rtl/clksel_div.sv
`timescale 1ns/1ps
// Output divider running on the selected clock.
module clksel_div #(
   parameter int unsigned DIV_W       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             mux_clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_val,
   output logic             div_clk
);
   logic [DIV_W-1:0] div_s [SYNC_STAGES];
   logic [DIV_W-1:0] cnt;
   logic             tog;

   always_ff @(posedge mux_clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SYNC_STAGES; s++) div_s[s] <= '0;
      end else begin
         div_s[0] <= div_val;
         for (int s = 1; s < SYNC_STAGES; s++) div_s[s] <= div_s[s-1];
      end
   end

   always_ff @(posedge mux_clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         tog <= 1'b0;
      end else if (div_s[SYNC_STAGES-1] == '0) begin
         cnt <= '0;
         tog <= 1'b0;
      end else if (cnt >= div_s[SYNC_STAGES-1] - DIV_W'(1)) begin
         cnt <= '0;
         tog <= ~tog;
      end else begin
         cnt <= cnt + DIV_W'(1);
      end
   end

   assign div_clk = tog;
endmodule

// File: rtl/clksel_top.sv
`timescale 1ns/1ps
module clksel_top #(
   parameter int unsigned N_SRC       = 4,
   parameter int unsigned SEL_W       = 2,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned DIV_W       = 8,
   parameter bit          DIV_EN      = 1'b1,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                          cfg_clk_i,
   input  logic                          cfg_rst_ni,
   input  logic                          wr_en_i,
   input  logic [clksel_pkg::ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0]             wr_data_i,
   input  logic [N_SRC-1:0]              src_clk_i,
   output logic                          mux_clk_o,
   output logic                          div_clk_o,
   output logic [SEL_W-1:0]              act_sel_o,
   output logic                          busy_o
);
   localparam int unsigned NCODE = 1 << SEL_W;

   // elaboration-time parameter checks
   if (N_SRC < 2 || N_SRC > NCODE) begin : g_bad_nsrc
      $error("clksel_top: N_SRC must lie in 2..2**SEL_W");
   end
   if (DIV_W > DATA_W || SEL_W > DATA_W) begin : g_bad_width
      $error("clksel_top: field wider than the data bus");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("clksel_top: at least two synchroniser stages needed");
   end

   logic [SEL_W-1:0] act_sel;
   logic [DIV_W-1:0] div_val;
   logic [NCODE-1:0] lane_en;
   logic [NCODE-1:0] lane_req;

   clksel_regs #(.SEL_W(SEL_W), .DATA_W(DATA_W), .DIV_W(DIV_W)) u_regs (
      .cfg_clk (cfg_clk_i),
      .rst_n   (cfg_rst_ni),
      .wr_en   (wr_en_i),
      .wr_addr (wr_addr_i),
      .wr_data (wr_data_i),
      .act_sel (act_sel),
      .div_val (div_val)
   );

   // a lane may request only when every other lane has dropped its enable
   for (genvar i = 0; i < NCODE; i++) begin : g_lane
      if (i < N_SRC) begin : g_pop
         assign lane_req[i] = (act_sel == SEL_W'(i)) &&
                              ((lane_en & ~(NCODE'(1) << i)) == '0);
         clksel_lane #(.SYNC_STAGES(SYNC_STAGES)) u_lane (
            .src_clk (src_clk_i[i]),
            .rst_n   (cfg_rst_ni),
            .req     (lane_req[i]),
            .en      (lane_en[i])
         );
      end else begin : g_empty
         assign lane_req[i] = 1'b0;
         assign lane_en[i]  = 1'b0;
      end
   end

   assign mux_clk_o = |(src_clk_i & lane_en[N_SRC-1:0]);

   clksel_status #(.SEL_W(SEL_W), .N_SRC(N_SRC), .SYNC_STAGES(SYNC_STAGES)) u_status (
      .cfg_clk (cfg_clk_i),
      .rst_n   (cfg_rst_ni),
      .act_sel (act_sel),
      .lane_en (lane_en),
      .busy    (busy_o)
   );

   if (DIV_EN) begin : g_div
      clksel_div #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_div (
         .mux_clk (mux_clk_o),
         .rst_n   (cfg_rst_ni),
         .div_val (div_val),
         .div_clk (div_clk_o)
      );
   end else begin : g_nodiv
      assign div_clk_o = 1'b0;
   end

   assign act_sel_o = act_sel;
endmodule

// File: rtl/clksel_chk.sv
`timescale 1ns/1ps
module clksel_chk #(
   parameter int unsigned SEL_W  = 2,
   parameter int unsigned N_SRC  = 4,
   parameter int unsigned DATA_W = 8,
   localparam int unsigned NCODE = 1 << SEL_W
) (
   input logic                          cfg_clk,
   input logic                          rst_n,
   input logic                          wr_en,
   input logic [clksel_pkg::ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0]             wr_data,
   input logic [SEL_W-1:0]              act_sel,
   input logic                          busy,
   input logic [NCODE-1:0]              lane_en
);
   import clksel_pkg::*;

   assert_one_lane_R7: assert property (@(posedge cfg_clk) disable iff (!rst_n)
      $onehot0(lane_en));

   assert_sel_write_no_effect_R2: assert property (@(posedge cfg_clk) disable iff (!rst_n)
      (wr_en && wr_addr == REG_SEL) |=> $stable(act_sel));

   assert_commit_only_on_update_R3: assert property (@(posedge cfg_clk) disable iff (!rst_n)
      !(wr_en && wr_addr == REG_UPD && wr_data[0]) |=> $stable(act_sel));

   assert_busy_on_change_R8: assert property (@(posedge cfg_clk) disable iff (!rst_n)
      (act_sel != $past(act_sel)) |-> busy);

   assert_empty_code_dark_R9: assert property (@(posedge cfg_clk) disable iff (!rst_n)
      (act_sel >= N_SRC && !busy) |-> (lane_en == '0));
endmodule

bind clksel_top clksel_chk #(.SEL_W(SEL_W), .N_SRC(N_SRC), .DATA_W(DATA_W)) u_chk (
   .cfg_clk (cfg_clk_i),
   .rst_n   (cfg_rst_ni),
   .wr_en   (wr_en_i),
   .wr_addr (wr_addr_i),
   .wr_data (wr_data_i),
   .act_sel (act_sel_o),
   .busy    (busy_o),
   .lane_en (lane_en)
);

// File: tb/sim_clksel_top.sv
`timescale 1ns/1ps
module sim_clksel_top;
   logic       cfg_clk = 1'b0;
   logic       rst_n   = 1'b0;
   logic       wr_en0 = 1'b0, wr_en1 = 1'b0;
   logic [1:0] wr_addr0 = '0, wr_addr1 = '0;
   logic [7:0] wr_data0 = '0, wr_data1 = '0;
   logic [3:0] src0 = '0;
   logic [2:0] src1 = '0;
   logic       mux0, div0, busy0, mux1, div1, busy1;
   logic [1:0] act0, act1;

   int n_chk = 0, n_fail = 0;
   int n_glitch = 0, n_merge = 0;
   int edges1 = 0, edges_div0 = 0;
   bit mon_on = 1'b0;
   realtime t_r = 0, t_f = 0;

   always #4 cfg_clk = ~cfg_clk;            // 125 MHz
   always #5  src0[0] = ~src0[0];           // 10 ns
   always #7  src0[1] = ~src0[1];           // 14 ns
   always #11 src0[2] = ~src0[2];           // 22 ns
   always #3  src0[3] = ~src0[3];           // 6 ns
   always #5  src1[0] = ~src1[0];           // 10 ns
   always #9  src1[1] = ~src1[1];           // 18 ns
   always #13 src1[2] = ~src1[2];           // 26 ns

   clksel_top u0 (
      .cfg_clk_i(cfg_clk), .cfg_rst_ni(rst_n), .wr_en_i(wr_en0),
      .wr_addr_i(wr_addr0), .wr_data_i(wr_data0), .src_clk_i(src0),
      .mux_clk_o(mux0), .div_clk_o(div0), .act_sel_o(act0), .busy_o(busy0));

   clksel_top #(.N_SRC(3), .DIV_EN(1'b0)) u1 (
      .cfg_clk_i(cfg_clk), .cfg_rst_ni(rst_n), .wr_en_i(wr_en1),
      .wr_addr_i(wr_addr1), .wr_data_i(wr_data1), .src_clk_i(src1),
      .mux_clk_o(mux1), .div_clk_o(div1), .act_sel_o(act1), .busy_o(busy1));

   function automatic bit near(realtime a, realtime b);
      return (a > b - 0.01) && (a < b + 0.01);
   endfunction

   // pulse monitor on the main selector output (R6, R7)
   always @(posedge mux0) begin
      if (mon_on && t_f > 0 && ($realtime - t_f) < 2.99) n_glitch++;
      t_r = $realtime;
   end
   always @(negedge mux0) begin
      if (mon_on && t_r > 0) begin
         if (($realtime - t_r) < 2.99) n_glitch++;
         if (!(near($realtime - t_r, 3) || near($realtime - t_r, 5) ||
               near($realtime - t_r, 7) || near($realtime - t_r, 11))) n_merge++;
      end
      t_f = $realtime;
   end
   always @(posedge mux1) edges1++;
   always @(posedge div0) edges_div0++;

   task automatic chk_int(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic chk_real(string tag, realtime act, realtime exp);
      n_chk++;
      if (!near(act, exp)) begin
         n_fail++;
         $display("FAIL %s: actual %0.3f expected %0.3f", tag, act, exp);
      end
   endtask

   task automatic wr(int inst, logic [1:0] a, logic [7:0] d);
      @(negedge cfg_clk);
      if (inst == 0) begin wr_en0 = 1'b1; wr_addr0 = a; wr_data0 = d; end
      else           begin wr_en1 = 1'b1; wr_addr1 = a; wr_data1 = d; end
      @(negedge cfg_clk);
      wr_en0 = 1'b0; wr_en1 = 1'b0;
   endtask

   task automatic wait_idle(int inst);
      for (int i = 0; i < 400; i++) begin
         if ((inst == 0 ? busy0 : busy1) == 1'b0) break;
         @(negedge cfg_clk);
      end
      chk_int("R8 status clears", int'(inst == 0 ? busy0 : busy1), 0);
   endtask

   task automatic period(int which, output realtime p);
      realtime t1;
      if (which == 0) begin
         @(posedge mux0); @(posedge mux0); t1 = $realtime; @(posedge mux0);
      end else if (which == 1) begin
         @(posedge mux1); @(posedge mux1); t1 = $realtime; @(posedge mux1);
      end else begin
         @(posedge div0); @(posedge div0); t1 = $realtime; @(posedge div0);
      end
      p = $realtime - t1;
      @(negedge cfg_clk);
   endtask

   task automatic t_reset();
      realtime p;
      chk_int("R1 code after reset u0", int'(act0), 0);
      chk_int("R1 code after reset u1", int'(act1), 0);
      wait_idle(0);
      wait_idle(1);
      period(0, p); chk_real("R1 R5 u0 follows source 0", p, 10);
      period(1, p); chk_real("R1 u1 follows source 0", p, 10);
      period(2, p); chk_real("R1 R10 divider reset value 1", p, 20);
   endtask

   task automatic t_select_only();
      realtime p;
      wr(0, 2'd0, 8'd2);
      repeat (20) @(negedge cfg_clk);
      chk_int("R2 code unchanged", int'(act0), 0);
      chk_int("R2 not busy", int'(busy0), 0);
      period(0, p); chk_real("R2 output unchanged", p, 10);
   endtask

   task automatic t_update_handshake();
      realtime p;
      wr(0, 2'd1, 8'd1);                    // 1 without a 0 first
      repeat (10) @(negedge cfg_clk);
      chk_int("R3 lone 1 ignored", int'(act0), 0);
      wr(0, 2'd1, 8'd0);
      wr(0, 2'd1, 8'd1);
      chk_int("R3 commit after 0 then 1", int'(act0), 2);
      chk_int("R8 busy after commit", int'(busy0), 1);
      wait_idle(0);
      period(0, p); chk_real("R5 code 2 source", p, 22);
      wr(0, 2'd0, 8'd3);
      wr(0, 2'd1, 8'd1);                    // second 1, not re-armed
      repeat (10) @(negedge cfg_clk);
      chk_int("R3 repeated 1 ignored", int'(act0), 2);
   endtask

   task automatic t_low_bits();
      realtime p;
      wr(0, 2'd0, 8'hFD);                   // low bits 01
      wr(0, 2'd1, 8'd0);
      wr(0, 2'd1, 8'd1);
      chk_int("R4 low bits decoded", int'(act0), 1);
      wait_idle(0);
      period(0, p); chk_real("R4 R5 code 1 source", p, 14);
      wr(0, 2'd0, 8'd3);
      wr(0, 2'd1, 8'd0);
      wr(0, 2'd1, 8'd1);
      wait_idle(0);
      chk_int("R5 code 3 read-back", int'(act0), 3);
      period(0, p); chk_real("R5 code 3 source", p, 6);
   endtask

   task automatic t_divider();
      realtime p;
      int e0;
      wr(0, 2'd2, 8'd3);
      repeat (20) @(negedge cfg_clk);
      period(2, p); chk_real("R10 divide by 3", p, 36);
      wr(0, 2'd2, 8'd0);
      repeat (20) @(negedge cfg_clk);
      e0 = edges_div0;
      repeat (30) @(negedge cfg_clk);
      chk_int("R10 zero gates off", edges_div0 - e0, 0);
      chk_int("R10 gated level low", int'(div0), 0);
   endtask

   task automatic t_empty_code();
      realtime p;
      int e1;
      wr(1, 2'd0, 8'd3);
      wr(1, 2'd1, 8'd0);
      wr(1, 2'd1, 8'd1);
      chk_int("R9 empty code read-back", int'(act1), 3);
      wait_idle(1);
      e1 = edges1;
      repeat (30) @(negedge cfg_clk);
      chk_int("R9 output held low", edges1 - e1, 0);
      chk_int("R9 level low", int'(mux1), 0);
      wr(1, 2'd0, 8'd1);
      wr(1, 2'd1, 8'd0);
      wr(1, 2'd1, 8'd1);
      wait_idle(1);
      period(1, p); chk_real("R5 u1 code 1 source", p, 18);
   endtask

   initial begin
      repeat (3) @(negedge cfg_clk);
      rst_n = 1'b1;
      mon_on = 1'b1;
      @(negedge cfg_clk);
      t_reset();
      t_select_only();
      t_update_handshake();
      t_low_bits();
      t_divider();
      t_empty_code();
      chk_int("R6 no short phase", n_glitch, 0);
      chk_int("R7 no merged pulse", n_merge, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #500000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule